// File: doc/BRIEF.md
# TDM Loopback and Compare Router

This block sits between the serial side of a time-division multiplexed port and its three per-channel byte buffers: two transmit buffers (primary and secondary) and one receive buffer. Each clock cycle is one bit cell. A frame holds `CHANS` channels of `BITS` bits each, sent MSB first. A frame-sync pulse marks the first bit of a frame. The block routes the serial input pin, the primary transmit stream and the secondary transmit stream onto the receive sink and the two serial output pins.

Two 2-bit configuration fields choose the routing. The loop field sets the internal loopbacks of the primary pair. The secondary field picks what the second output carries: the secondary transmit stream, a one-frame-delayed echo of the input, the input XORed with the secondary stream, or the previous frame XORed with the current frame. The delayed modes use the secondary transmit buffer as the delay store. Each input byte is written back into that buffer's slot for the same channel, one cycle after that channel's last bit. Configuration changes are held until the next frame-sync pulse, so a frame never switches routing partway through.

A small controller tracks the bit and channel position. It has two states. HUNT is the state after reset: the position is unknown and no buffer writes occur. LOCKED is the state in which the position counters run. The transition HUNT→LOCKED is taken on the first frame-sync pulse. In LOCKED the counters wrap on their own at the end of a frame. Any frame-sync pulse, including one that arrives mid-frame, forces the position back to bit 0 of channel 0.

Top module: `tdm_loop_router`

## Requirements
- R1: After reset, and until the first frame-sync pulse, the routing is the normal setting (both fields 00), whatever the configuration inputs hold, and the write strobe is low.
- R2: Loop field 00: the receive sink takes the serial input, and output 0 carries the primary transmit stream.
- R3: Loop field 01: output 0 carries the serial input, and the receive sink still takes the serial input.
- R4: Loop field 10: the receive sink and output 0 both carry the primary transmit stream, and the serial input has no effect on either.
- R5: Loop field 11: the receive sink takes the primary transmit stream, and output 0 carries the serial input.
- R6: Secondary field 00: output 1 carries the secondary transmit stream, and no buffer writes occur.
- R7: Secondary field 01: every input byte is written back to its channel's slot, and output 1 carries the secondary stream, so output 1 repeats the input one frame later.
- R8: Secondary field 10: output 1 is the bitwise XOR of the serial input and the secondary stream, with no buffer writes.
- R9: Secondary field 11: input bytes are written back as in R7, and output 1 is the XOR of the stored previous-frame byte with the current input.
- R10: Configuration values are sampled only in a frame-sync cycle, and that cycle already uses them. A change made mid-frame has no effect on any output until the next frame-sync pulse.
- R11: When a write is enabled, the write strobe is high for exactly the one cycle after the last bit of channel c. In that cycle the channel output equals c and the data output holds that channel's `BITS` input bits, the first-received bit in the MSB.
- R12: No write occurs in HUNT. A frame-sync pulse in LOCKED at any position restarts the count at bit 0 of channel 0, and without pulses the count wraps freely from frame to frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-cell clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | High during the first bit cell of a frame |
| loop_cfg | input | 2 | Requested loopback setting of the primary pair |
| out1_cfg | input | 2 | Requested function of output 1 |
| ser_in | input | 1 | Serial input pin bit |
| tx0_bit | input | 1 | Current bit from the primary transmit buffer |
| tx1_bit | input | 1 | Current bit from the secondary transmit buffer |
| rx0_bit | output | 1 | Bit delivered to the receive buffer |
| ser_out0 | output | 1 | Serial output pin 0 |
| ser_out1 | output | 1 | Serial output pin 1 |
| tx1_wr_en | output | 1 | Write strobe into the secondary transmit buffer |
| tx1_wr_chan | output | $clog2(CHANS) | Channel slot being written |
| tx1_wr_data | output | BITS | Byte being written |

## Verification
All sixteen pairings of the two fields are run in a small four-channel configuration. The input, primary and secondary streams carry byte patterns that differ by frame and by channel, so swapped sources, missing XORs and stale frames all give different bits. Each new setting is requested mid-frame, which separates routing applied at the frame boundary from routing applied at once. A free-running stretch without frame-sync pulses and an early, misaligned pulse show the counter wrap and the restart. A delayed mode reproduces the previous frame's input only when both the write timing and the channel index are right.

// File: rtl/tlr_pkg.sv
package tlr_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL    = 2'b00,
        LB_IN_TO_OUT = 2'b01,
        LB_TX_TO_RX  = 2'b10,
        LB_CROSS     = 2'b11
    } loop_mode_e;

    typedef enum logic [1:0] {
        O1_TX   = 2'b00,
        O1_ECHO = 2'b01,
        O1_XOR  = 2'b10,
        O1_DIFF = 2'b11
    } out1_mode_e;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } sync_state_e;

endpackage

// File: rtl/tlr_frame_pos.sv
module tlr_frame_pos
    import tlr_pkg::*;
#(
    parameter int CHANS = 32,
    parameter int BITS  = 8,
    localparam int BIT_W = (BITS  > 1) ? $clog2(BITS)  : 1,
    localparam int CH_W  = (CHANS > 1) ? $clog2(CHANS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    output logic             pos_valid,
    output logic             chan_end,
    output logic [CH_W-1:0]  cur_chan
);

    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BITS - 1);
    localparam logic [CH_W-1:0]  LAST_CHAN = CH_W'(CHANS - 1);

    sync_state_e       state_q, state_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [CH_W-1:0]   chan_q, chan_d;
    logic [BIT_W-1:0]  cur_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            bit_q   <= '0;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            chan_q  <= chan_d;
        end
    end

    // next state and position
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:   if (frame_sync) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
        endcase
    end

    // outputs and counter advance
    always_comb begin
        cur_bit   = frame_sync ? '0 : bit_q;
        cur_chan  = frame_sync ? '0 : chan_q;
        pos_valid = frame_sync || (state_q == ST_LOCKED);
        chan_end  = pos_valid && (cur_bit == LAST_BIT);
        bit_d     = bit_q;
        chan_d    = chan_q;
        if (pos_valid) begin
            if (cur_bit == LAST_BIT) begin
                bit_d  = '0;
                chan_d = (cur_chan == LAST_CHAN) ? '0 : cur_chan + 1'b1;
            end else begin
                bit_d  = cur_bit + 1'b1;
                chan_d = cur_chan;
            end
        end
    end

endmodule

// File: rtl/tlr_route_core.sv
module tlr_route_core
    import tlr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_sync,
    input  logic [1:0] loop_cfg,
    input  logic [1:0] out1_cfg,
    input  logic       ser_in,
    input  logic       tx0_bit,
    input  logic       tx1_bit,
    output logic       rx0_bit,
    output logic       ser_out0,
    output logic       ser_out1,
    output logic       store_en,
    output logic [1:0] loop_active
);

    loop_mode_e act_loop_q, eff_loop;
    out1_mode_e act_out1_q, eff_out1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_loop_q <= LB_NORMAL;
            act_out1_q <= O1_TX;
        end else if (frame_sync) begin
            act_loop_q <= loop_mode_e'(loop_cfg);
            act_out1_q <= out1_mode_e'(out1_cfg);
        end
    end

    always_comb begin
        eff_loop = frame_sync ? loop_mode_e'(loop_cfg) : act_loop_q;
        eff_out1 = frame_sync ? out1_mode_e'(out1_cfg) : act_out1_q;
        unique case (eff_loop)
            LB_NORMAL:    begin rx0_bit = ser_in;  ser_out0 = tx0_bit; end
            LB_IN_TO_OUT: begin rx0_bit = ser_in;  ser_out0 = ser_in;  end
            LB_TX_TO_RX:  begin rx0_bit = tx0_bit; ser_out0 = tx0_bit; end
            LB_CROSS:     begin rx0_bit = tx0_bit; ser_out0 = ser_in;  end
        endcase
        unique case (eff_out1)
            O1_TX:   begin ser_out1 = tx1_bit;          store_en = 1'b0; end
            O1_ECHO: begin ser_out1 = tx1_bit;          store_en = 1'b1; end
            O1_XOR:  begin ser_out1 = tx1_bit ^ ser_in; store_en = 1'b0; end
            O1_DIFF: begin ser_out1 = tx1_bit ^ ser_in; store_en = 1'b1; end
        endcase
        loop_active = act_loop_q;
    end

endmodule

// File: rtl/tlr_byte_capture.sv
module tlr_byte_capture #(
    parameter int CHANS = 32,
    parameter int BITS  = 8,
    localparam int CH_W = (CHANS > 1) ? $clog2(CHANS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             chan_end,
    input  logic             store_en,
    input  logic [CH_W-1:0]  cur_chan,
    output logic             wr_en,
    output logic [CH_W-1:0]  wr_chan,
    output logic [BITS-1:0]  wr_data
);

    logic [BITS-1:0] shift_q;
    logic [BITS-1:0] byte_now;

    always_comb byte_now = {shift_q[BITS-2:0], ser_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            wr_en   <= 1'b0;
            wr_chan <= '0;
            wr_data <= '0;
        end else begin
            shift_q <= byte_now;
            wr_en   <= chan_end && store_en;
            if (chan_end && store_en) begin
                wr_chan <= cur_chan;
                wr_data <= byte_now;
            end
        end
    end

endmodule

// File: rtl/tdm_loop_router.sv
module tdm_loop_router #(
    parameter int CHANS = 32,
    parameter int BITS  = 8,
    localparam int CH_W = (CHANS > 1) ? $clog2(CHANS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic [1:0]       loop_cfg,
    input  logic [1:0]       out1_cfg,
    input  logic             ser_in,
    input  logic             tx0_bit,
    input  logic             tx1_bit,
    output logic             rx0_bit,
    output logic             ser_out0,
    output logic             ser_out1,
    output logic             tx1_wr_en,
    output logic [CH_W-1:0]  tx1_wr_chan,
    output logic [BITS-1:0]  tx1_wr_data
);

    logic            pos_valid;
    logic            chan_end;
    logic [CH_W-1:0] cur_chan;
    logic            store_en;
    logic [1:0]      loop_active;

    tlr_frame_pos #(.CHANS(CHANS), .BITS(BITS)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .pos_valid  (pos_valid),
        .chan_end   (chan_end),
        .cur_chan   (cur_chan)
    );

    tlr_route_core u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_sync  (frame_sync),
        .loop_cfg    (loop_cfg),
        .out1_cfg    (out1_cfg),
        .ser_in      (ser_in),
        .tx0_bit     (tx0_bit),
        .tx1_bit     (tx1_bit),
        .rx0_bit     (rx0_bit),
        .ser_out0    (ser_out0),
        .ser_out1    (ser_out1),
        .store_en    (store_en),
        .loop_active (loop_active)
    );

    tlr_byte_capture #(.CHANS(CHANS), .BITS(BITS)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .chan_end (chan_end),
        .store_en (store_en && pos_valid),
        .cur_chan (cur_chan),
        .wr_en    (tx1_wr_en),
        .wr_chan  (tx1_wr_chan),
        .wr_data  (tx1_wr_data)
    );

endmodule

// File: rtl/tlr_checks.sv
module tlr_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_sync,
    input logic       ser_in,
    input logic       tx0_bit,
    input logic       tx1_bit,
    input logic       rx0_bit,
    input logic       ser_out0,
    input logic       ser_out1,
    input logic       tx1_wr_en,
    input logic [1:0] loop_active
);

    logic seen_sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_sync_q <= 1'b0;
        else if (frame_sync) seen_sync_q <= 1'b1;
    end

    // R11
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx1_wr_en |=> !tx1_wr_en);

    // R12
    no_wr_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sync_q |-> !tx1_wr_en);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(loop_active));

    // R3
    out0_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_out0 == ser_in) || (ser_out0 == tx0_bit));

    // R4
    rx_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx0_bit == ser_in) || (rx0_bit == tx0_bit));

    // R8
    out1_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_out1 == tx1_bit) || (ser_out1 == (tx1_bit ^ ser_in)));

endmodule

bind tdm_loop_router tlr_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_sync  (frame_sync),
    .ser_in      (ser_in),
    .tx0_bit     (tx0_bit),
    .tx1_bit     (tx1_bit),
    .rx0_bit     (rx0_bit),
    .ser_out0    (ser_out0),
    .ser_out1    (ser_out1),
    .tx1_wr_en   (tx1_wr_en),
    .loop_active (loop_active)
);

// File: tb/tdm_loop_router_test.sv
module tdm_loop_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int CHANS = 4;
    localparam int BITS  = 8;
    localparam int CH_W  = 2;
    localparam int FRAME = CHANS * BITS;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            frame_sync;
    logic [1:0]      loop_cfg, out1_cfg;
    logic            ser_in, tx0_bit, tx1_bit;
    logic            rx0_bit, ser_out0, ser_out1, tx1_wr_en;
    logic [CH_W-1:0] tx1_wr_chan;
    logic [BITS-1:0] tx1_wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_loop_router #(.CHANS(CHANS), .BITS(BITS)) uut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .loop_cfg(loop_cfg), .out1_cfg(out1_cfg),
        .ser_in(ser_in), .tx0_bit(tx0_bit), .tx1_bit(tx1_bit),
        .rx0_bit(rx0_bit), .ser_out0(ser_out0), .ser_out1(ser_out1),
        .tx1_wr_en(tx1_wr_en), .tx1_wr_chan(tx1_wr_chan), .tx1_wr_data(tx1_wr_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    bit         b_locked;
    int         b_bit, b_chan, b_frame, cyc;
    logic [1:0] act_lb, act_o1;
    bit         pend;
    int         pend_chan;
    logic [7:0] pend_data, sh;
    logic [7:0] mem [CHANS];

    function automatic logic [7:0] ser_byte(int f, int c);
        return 8'((f * 29 + c * 83 + 7) ^ (f << 3));
    endfunction

    function automatic logic [7:0] tx0_byte(int f, int c);
        return 8'(f * 53 + c * 19 + 200);
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic cycle(bit sync);
        int cb, cc;
        bit valid;
        logic s, t0, t1;
        logic [7:0] sb, tb;
        logic [1:0] elb, eo1;
        string tlb, to1, twr;
        @(negedge clk);
        if (sync) begin cb = 0; cc = 0; valid = 1; end
        else begin cb = b_bit; cc = b_chan; valid = b_locked; end
        if (valid && cb == 0 && cc == 0) b_frame++;
        if (valid) begin
            sb = ser_byte(b_frame, cc);
            tb = tx0_byte(b_frame, cc);
            s  = sb[BITS-1-cb];
            t0 = tb[BITS-1-cb];
            t1 = mem[cc][BITS-1-cb];
        end else begin
            s  = cyc[0] ^ cyc[2];
            t0 = cyc[1];
            t1 = cyc[0] ^ cyc[3];
        end
        frame_sync = sync;
        ser_in = s; tx0_bit = t0; tx1_bit = t1;
        elb = sync ? loop_cfg : act_lb;
        eo1 = sync ? out1_cfg : act_o1;
        #(CLK_PERIOD/4);
        if (!b_locked && !sync) begin tlb = "R1"; to1 = "R1"; end
        else if (!sync && (loop_cfg != act_lb || out1_cfg != act_o1)) begin tlb = "R10"; to1 = "R10"; end
        else begin
            case (elb) 2'd0: tlb = "R2"; 2'd1: tlb = "R3"; 2'd2: tlb = "R4"; default: tlb = "R5"; endcase
            case (eo1) 2'd0: to1 = "R6"; 2'd1: to1 = "R7"; 2'd2: to1 = "R8"; default: to1 = "R9"; endcase
        end
        twr = valid ? "R11" : "R12";
        chk(tlb, "rx0_bit",  {7'd0, rx0_bit},  {7'd0, elb[1] ? t0 : s});
        chk(tlb, "ser_out0", {7'd0, ser_out0}, {7'd0, elb[0] ? s : t0});
        chk(to1, "ser_out1", {7'd0, ser_out1}, {7'd0, t1 ^ (eo1[1] & s)});
        chk(twr, "tx1_wr_en", {7'd0, tx1_wr_en}, {7'd0, pend});
        if (pend) begin
            chk("R11", "tx1_wr_chan", 8'(tx1_wr_chan), 8'(pend_chan));
            chk("R11", "tx1_wr_data", tx1_wr_data, pend_data);
            mem[pend_chan] = pend_data;
        end
        pend = valid && (cb == BITS - 1) && eo1[0];
        pend_chan = cc;
        pend_data = {sh[6:0], s};
        sh = {sh[6:0], s};
        if (sync) begin act_lb = loop_cfg; act_o1 = out1_cfg; b_locked = 1; end
        if (valid) begin
            if (cb == BITS - 1) begin
                b_bit = 0;
                b_chan = (cc == CHANS - 1) ? 0 : cc + 1;
            end else begin
                b_bit = cb + 1;
                b_chan = cc;
            end
        end
        cyc++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        b_locked = 0; b_bit = 0; b_chan = 0; b_frame = 0; cyc = 0;
        act_lb = 2'b00; act_o1 = 2'b00; pend = 0; pend_chan = 0;
        pend_data = '0; sh = '0;
        for (int i = 0; i < CHANS; i++) mem[i] = 8'(i * 37 + 8'h5A);
        rst_n = 1'b0; frame_sync = 1'b0;
        loop_cfg = 2'b01; out1_cfg = 2'b11;
        ser_in = 1'b0; tx0_bit = 1'b0; tx1_bit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "tx1_wr_en after reset", {7'd0, tx1_wr_en}, 8'd0);
        // R1 / R12: hunting, requested settings ignored, no writes
        repeat (20) cycle(1'b0);
        // sweep every pairing of the two fields, changed mid-frame (R10)
        for (int lb = 0; lb < 4; lb++) begin
            for (int o1 = 0; o1 < 4; o1++) begin
                for (int f = 0; f < 3; f++) begin
                    for (int k = 0; k < FRAME; k++) begin
                        if (f == 0 && k == 13) begin
                            loop_cfg = 2'(lb);
                            out1_cfg = 2'(o1);
                        end
                        cycle(k == 0);
                    end
                end
            end
        end
        // R12: free-running wrap without pulses, delayed echo active (R7)
        loop_cfg = 2'b11; out1_cfg = 2'b01;
        for (int k = 0; k < 3 * FRAME; k++) cycle(k == 0);
        // R12: misaligned pulse restarts the count, difference mode (R9)
        out1_cfg = 2'b11;
        cycle(1'b1);
        repeat (16) cycle(1'b0);
        for (int f = 0; f < 3; f++)
            for (int k = 0; k < FRAME; k++) cycle(k == 0);
        summary();
        $finish;
    end

endmodule